// File: doc/BRIEF.md
# Indexed Display Register Port

This block is the software-facing register window of a display controller. Software reaches a large register space through two 32-bit ports. It first writes a register number to the selector port. It then reads or writes that register through the data port. The window holds several kinds of register: the version word that driver and hardware agree on, the mode settings (width, height, colour depth and derived line pitch), a fixed capability word, and the hardware cursor state. Above a reserved colour-map range sits a bank of general scratch words.

Writes are checked before they take effect. A version word outside the three legal values is dropped, and so is a width or height beyond the mode limits. In both cases the register keeps its old value. A write to the sync register sends a one-cycle start strobe to the command consumer. The busy register then reads 1 until that consumer reports idle. Read data comes back one cycle after the read request, qualified by a valid flag.

Top module: `display_regport`

## Requirements
- R1: A write to port 0 stores the full 32-bit selector; a read of port 0 returns it. Every read request is answered with rd_valid high, and rd_data valid, in the following cycle.
- R2: Register 0 (version) resets to 0x90000002. A write is accepted only if it equals 0x90000000, 0x90000001 or 0x90000002; any other value leaves the register unchanged.
- R3: Register 2 (width) accepts a write no greater than MAX_WIDTH (2368). Register 3 (height) accepts a write no greater than MAX_HEIGHT (1770). A larger value leaves the register unchanged.
- R4: Registers 4 and 5 read MAX_WIDTH and MAX_HEIGHT.
- R5: With DEPTH_BITS of 32, register 6 (depth) reads 24, registers 7 and 28 (pixel size) read 32, and register 12 (line pitch) reads width*32/8.
- R6: Register 17 (capabilities) reads 0x000000E3: bits 0 and 1 for fill and copy, bits 5, 6 and 7 for the cursor and its two bypass modes.
- R7: Register 27 (cursor visibility) becomes 1 on a write of 1 and 0 on a write of 0. Any other code, including 2 and 3, leaves it unchanged. Registers 24, 25 and 26 (cursor id, x, y) store what is written.
- R8: Selectors 1024 to 1791 (colour map), and any selector not given a meaning here, read 0 and ignore writes.
- R9: Selectors 1792 to 1792+SCRATCH_WORDS-1 are read/write scratch words. One past the end behaves as R8. Register 29 reads SCRATCH_WORDS (16).
- R10: A write of any value to register 21 raises sync_start for exactly the next cycle. Register 22 (busy) then reads 1 until consumer_idle is seen high in a cycle after the strobe.
- R11: A read of port 2 returns 0 and a read of port 3 returns 0xFFFFFFFF. Writes to ports 2 and 3 change no state.
- R12: After reset: selector 0, width 640, height 480, cursor hidden, enable 0, config 0, busy 0, sync_start 0, rd_valid 0.
- R13: Register 1 (enable) and register 20 (config done) read 1 after a non-zero write and 0 after a zero write. Register 23 (guest id) stores the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Access request this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_port | input | 2 | 0 selector, 1 data, 2 and 3 inert |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after request) |
| rd_data | output | 32 | Read data |
| sync_start | output | 1 | One-cycle strobe to the command consumer |
| consumer_idle | input | 1 | Command consumer has nothing in progress |

## Verification
The bench aims at the edges of each validation rule. It writes exactly the limit and one above it for width and height, and a near-miss version word. A design with an off-by-one comparison would take 2369, or lose 1770. The bench drives the cursor visibility codes 2 and 3 from both the shown and the hidden state; a design that decoded them as set or clear would flip the cursor. It probes the last colour-map selector, the last scratch word and the word just past it, where a range error would alias storage. The sync test holds the consumer busy to prove that the busy flag does not clear on the strobe cycle itself.

// File: rtl/regport_pkg.sv
// Shared constants and the register-select type for the indexed display
// register port. Assumes 32-bit registers and selectors.
package regport_pkg;

    localparam logic [31:0] VER_0 = 32'h9000_0000;
    localparam logic [31:0] VER_1 = 32'h9000_0001;
    localparam logic [31:0] VER_2 = 32'h9000_0002;

    // Capability word: fill, copy, cursor, both cursor bypass modes.
    localparam logic [31:0] CAP_WORD = 32'h0000_00E3;

    localparam logic [31:0] CUR_HIDE = 32'd0;
    localparam logic [31:0] CUR_SHOW = 32'd1;

    typedef enum logic [4:0] {
        SEL_NONE,
        SEL_VER,
        SEL_ENABLE,
        SEL_WIDTH,
        SEL_HEIGHT,
        SEL_MAXW,
        SEL_MAXH,
        SEL_DEPTH,
        SEL_PIXBITS,
        SEL_PITCH,
        SEL_CAPS,
        SEL_CONFIG,
        SEL_SYNC,
        SEL_BUSY,
        SEL_GUEST,
        SEL_CUR_ID,
        SEL_CUR_X,
        SEL_CUR_Y,
        SEL_CUR_ON,
        SEL_SCR_SIZE,
        SEL_SCRATCH
    } reg_sel_e;

endpackage

// File: rtl/regport_decode.sv
// Selector decoder: classifies the 32-bit selector into a register kind.
// Assumes the scratch bank begins right after the colour-map range; the
// colour map and every unlisted selector decode to SEL_NONE.
module regport_decode
    import regport_pkg::*;
#(
    parameter int unsigned SCR_BASE  = 1792,
    parameter int unsigned SCR_WORDS = 16
) (
    input  logic [31:0] index,
    output reg_sel_e    sel
);
    localparam logic [31:0] SCR_LO = 32'(SCR_BASE);
    localparam logic [31:0] SCR_HI = 32'(SCR_BASE + SCR_WORDS);

    // Map the selector value to a register kind.
    always_comb begin
        case (index)
            32'd0:   sel = SEL_VER;
            32'd1:   sel = SEL_ENABLE;
            32'd2:   sel = SEL_WIDTH;
            32'd3:   sel = SEL_HEIGHT;
            32'd4:   sel = SEL_MAXW;
            32'd5:   sel = SEL_MAXH;
            32'd6:   sel = SEL_DEPTH;
            32'd7:   sel = SEL_PIXBITS;
            32'd12:  sel = SEL_PITCH;
            32'd17:  sel = SEL_CAPS;
            32'd20:  sel = SEL_CONFIG;
            32'd21:  sel = SEL_SYNC;
            32'd22:  sel = SEL_BUSY;
            32'd23:  sel = SEL_GUEST;
            32'd24:  sel = SEL_CUR_ID;
            32'd25:  sel = SEL_CUR_X;
            32'd26:  sel = SEL_CUR_Y;
            32'd27:  sel = SEL_CUR_ON;
            32'd28:  sel = SEL_PIXBITS;
            32'd29:  sel = SEL_SCR_SIZE;
            default: sel = (index >= SCR_LO && index < SCR_HI) ? SEL_SCRATCH : SEL_NONE;
        endcase
    end

endmodule

// File: rtl/regport_mode.sv
// Mode and identity registers: version, enable, width, height, config done,
// guest id. Validates version, width and height writes; rejected writes
// leave the register untouched. Assumes wr is a one-cycle data-port write.
module regport_mode
    import regport_pkg::*;
#(
    parameter int unsigned MAX_WIDTH  = 2368,
    parameter int unsigned MAX_HEIGHT = 1770,
    parameter int unsigned DEF_WIDTH  = 640,
    parameter int unsigned DEF_HEIGHT = 480
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  reg_sel_e    sel,
    input  logic [31:0] wdata,
    output logic [31:0] ver_q,
    output logic        enable_q,
    output logic [31:0] width_q,
    output logic [31:0] height_q,
    output logic        config_q,
    output logic [31:0] guest_q
);
    localparam logic [31:0] W_LIM = 32'(MAX_WIDTH);
    localparam logic [31:0] H_LIM = 32'(MAX_HEIGHT);

    logic ver_ok;

    // Version word is accepted only if it matches a known revision.
    always_comb ver_ok = (wdata == VER_0) || (wdata == VER_1) || (wdata == VER_2);

    // Update the mode registers on accepted data-port writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ver_q    <= VER_2;
            enable_q <= 1'b0;
            width_q  <= 32'(DEF_WIDTH);
            height_q <= 32'(DEF_HEIGHT);
            config_q <= 1'b0;
            guest_q  <= 32'd0;
        end else if (wr) begin
            case (sel)
                SEL_VER:    if (ver_ok) ver_q <= wdata;
                SEL_ENABLE: enable_q <= |wdata;
                SEL_WIDTH:  if (wdata <= W_LIM) width_q <= wdata;
                SEL_HEIGHT: if (wdata <= H_LIM) height_q <= wdata;
                SEL_CONFIG: config_q <= |wdata;
                SEL_GUEST:  guest_q <= wdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/regport_cursor.sv
// Hardware cursor registers: id, x, y and visibility. Visibility is set only
// by code 1 and cleared only by code 0; every other code leaves it as is.
module regport_cursor
    import regport_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  reg_sel_e    sel,
    input  logic [31:0] wdata,
    output logic [31:0] cur_id_q,
    output logic [31:0] cur_x_q,
    output logic [31:0] cur_y_q,
    output logic        cur_on_q
);

    // Store cursor fields and apply the selective visibility codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_id_q <= 32'd0;
            cur_x_q  <= 32'd0;
            cur_y_q  <= 32'd0;
            cur_on_q <= 1'b0;
        end else if (wr) begin
            case (sel)
                SEL_CUR_ID: cur_id_q <= wdata;
                SEL_CUR_X:  cur_x_q  <= wdata;
                SEL_CUR_Y:  cur_y_q  <= wdata;
                SEL_CUR_ON: begin
                    if (wdata == CUR_SHOW)      cur_on_q <= 1'b1;
                    else if (wdata == CUR_HIDE) cur_on_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/regport_scratch.sv
// Scratch word bank. Each word owns a comparator against its own selector,
// so no subtraction sits in front of the array. Read data is the OR of the
// one word that matches (at most one can match).
module regport_scratch #(
    parameter int unsigned SCR_BASE  = 1792,
    parameter int unsigned SCR_WORDS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [31:0] index,
    input  logic [31:0] wdata,
    output logic [31:0] rdata
);
    logic [SCR_WORDS-1:0] hit;
    logic [31:0]          word_q [SCR_WORDS];

    for (genvar g = 0; g < SCR_WORDS; g++) begin : g_word
        // Selector match for this word.
        assign hit[g] = (index == 32'(SCR_BASE + g));

        // Write this word when its selector is active.
        always_ff @(posedge clk) begin
            if (!rst_n)           word_q[g] <= 32'd0;
            else if (wr && hit[g]) word_q[g] <= wdata;
        end
    end

    // Collect the matching word onto the read bus.
    always_comb begin
        rdata = 32'd0;
        for (int i = 0; i < SCR_WORDS; i++) begin
            if (hit[i]) rdata = rdata | word_q[i];
        end
    end

endmodule

// File: rtl/regport_sync.sv
// Sync handshake: a sync write raises a one-cycle start strobe and sets
// busy. Busy clears once the consumer reports idle in a cycle after the
// strobe, so an idle level left over from before the request is not taken.
module regport_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_wr,
    input  logic consumer_idle,
    output logic sync_start,
    output logic busy_q
);

    // Generate the strobe and track completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_start <= 1'b0;
            busy_q     <= 1'b0;
        end else begin
            sync_start <= sync_wr;
            if (sync_wr)                                 busy_q <= 1'b1;
            else if (busy_q && !sync_start && consumer_idle) busy_q <= 1'b0;
        end
    end

endmodule

// File: rtl/display_regport.sv
// Indexed register port for a display controller. Port 0 holds a 32-bit
// selector; port 1 reads or writes the selected register; ports 2 and 3
// are inert. Read data is registered and returned one cycle after the
// request. Assumes one access per cycle and 32-bit accesses only.
module display_regport
    import regport_pkg::*;
#(
    parameter int unsigned MAX_WIDTH     = 2368,
    parameter int unsigned MAX_HEIGHT    = 1770,
    parameter int unsigned DEF_WIDTH     = 640,
    parameter int unsigned DEF_HEIGHT    = 480,
    parameter int unsigned DEPTH_BITS    = 32,
    parameter int unsigned PAL_BASE      = 1024,
    parameter int unsigned PAL_WORDS     = 768,
    parameter int unsigned SCRATCH_WORDS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_en,
    input  logic        acc_we,
    input  logic [1:0]  acc_port,
    input  logic [31:0] acc_wdata,
    output logic        rd_valid,
    output logic [31:0] rd_data,
    output logic        sync_start,
    input  logic        consumer_idle
);
    localparam int unsigned SCR_BASE = PAL_BASE + PAL_WORDS;
    localparam logic [31:0] DEPTH_RD = (DEPTH_BITS == 32) ? 32'd24 : 32'(DEPTH_BITS);

    logic [31:0] index_q;
    reg_sel_e    sel;
    logic        idx_wr, val_wr, rd_req;
    logic [31:0] ver_q, width_q, height_q, guest_q;
    logic        enable_q, config_q;
    logic [31:0] cur_id_q, cur_x_q, cur_y_q;
    logic        cur_on_q;
    logic [31:0] scr_rdata;
    logic        busy_q;
    logic [31:0] value_rd, port_rd;

    // Split the access into selector write, data write and read request.
    always_comb begin
        idx_wr = acc_en && acc_we && (acc_port == 2'd0);
        val_wr = acc_en && acc_we && (acc_port == 2'd1);
        rd_req = acc_en && !acc_we;
    end

    // Hold the selector.
    always_ff @(posedge clk) begin
        if (!rst_n)      index_q <= 32'd0;
        else if (idx_wr) index_q <= acc_wdata;
    end

    regport_decode #(.SCR_BASE(SCR_BASE), .SCR_WORDS(SCRATCH_WORDS)) u_decode (
        .index (index_q),
        .sel   (sel)
    );

    regport_mode #(
        .MAX_WIDTH(MAX_WIDTH), .MAX_HEIGHT(MAX_HEIGHT),
        .DEF_WIDTH(DEF_WIDTH), .DEF_HEIGHT(DEF_HEIGHT)
    ) u_mode (
        .clk(clk), .rst_n(rst_n), .wr(val_wr), .sel(sel), .wdata(acc_wdata),
        .ver_q(ver_q), .enable_q(enable_q), .width_q(width_q),
        .height_q(height_q), .config_q(config_q), .guest_q(guest_q)
    );

    regport_cursor u_cursor (
        .clk(clk), .rst_n(rst_n), .wr(val_wr), .sel(sel), .wdata(acc_wdata),
        .cur_id_q(cur_id_q), .cur_x_q(cur_x_q), .cur_y_q(cur_y_q),
        .cur_on_q(cur_on_q)
    );

    regport_scratch #(.SCR_BASE(SCR_BASE), .SCR_WORDS(SCRATCH_WORDS)) u_scratch (
        .clk(clk), .rst_n(rst_n), .wr(val_wr), .index(index_q),
        .wdata(acc_wdata), .rdata(scr_rdata)
    );

    regport_sync u_sync (
        .clk(clk), .rst_n(rst_n), .sync_wr(val_wr && (sel == SEL_SYNC)),
        .consumer_idle(consumer_idle), .sync_start(sync_start), .busy_q(busy_q)
    );

    // Select the data-port read value for the current register.
    always_comb begin
        case (sel)
            SEL_VER:      value_rd = ver_q;
            SEL_ENABLE:   value_rd = {31'd0, enable_q};
            SEL_WIDTH:    value_rd = width_q;
            SEL_HEIGHT:   value_rd = height_q;
            SEL_MAXW:     value_rd = 32'(MAX_WIDTH);
            SEL_MAXH:     value_rd = 32'(MAX_HEIGHT);
            SEL_DEPTH:    value_rd = DEPTH_RD;
            SEL_PIXBITS:  value_rd = 32'(DEPTH_BITS);
            SEL_PITCH:    value_rd = (width_q * 32'(DEPTH_BITS)) >> 3;
            SEL_CAPS:     value_rd = CAP_WORD;
            SEL_CONFIG:   value_rd = {31'd0, config_q};
            SEL_BUSY:     value_rd = {31'd0, busy_q};
            SEL_GUEST:    value_rd = guest_q;
            SEL_CUR_ID:   value_rd = cur_id_q;
            SEL_CUR_X:    value_rd = cur_x_q;
            SEL_CUR_Y:    value_rd = cur_y_q;
            SEL_CUR_ON:   value_rd = {31'd0, cur_on_q};
            SEL_SCR_SIZE: value_rd = 32'(SCRATCH_WORDS);
            SEL_SCRATCH:  value_rd = scr_rdata;
            default:      value_rd = 32'd0;
        endcase
    end

    // Select by port.
    always_comb begin
        case (acc_port)
            2'd0:    port_rd = index_q;
            2'd1:    port_rd = value_rd;
            2'd2:    port_rd = 32'd0;
            default: port_rd = 32'hFFFF_FFFF;
        endcase
    end

    // Register the read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= 32'd0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) rd_data <= port_rd;
        end
    end

endmodule

// File: rtl/regport_checker.sv
// Property checker for display_regport, bound to every instance.
module regport_checker #(
    parameter int unsigned MAX_WIDTH  = 2368,
    parameter int unsigned MAX_HEIGHT = 1770
) (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_en,
    input logic        acc_we,
    input logic [1:0]  acc_port,
    input logic [31:0] acc_wdata,
    input logic [31:0] index_q,
    input logic [31:0] ver_q,
    input logic [31:0] width_q,
    input logic [31:0] height_q,
    input logic        cur_on_q,
    input logic        busy_q,
    input logic        sync_start,
    input logic        rd_valid
);
    logic data_wr;
    assign data_wr = acc_en && acc_we && (acc_port == 2'd1);

    assert_rd_response_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_we) |=> rd_valid);

    assert_ver_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ver_q == 32'h9000_0000) || (ver_q == 32'h9000_0001) || (ver_q == 32'h9000_0002));

    assert_width_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && index_q == 32'd2 && acc_wdata > 32'(MAX_WIDTH)) |=> $stable(width_q));

    assert_height_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && index_q == 32'd3 && acc_wdata > 32'(MAX_HEIGHT)) |=> $stable(height_q));

    assert_cursor_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && index_q == 32'd27 && acc_wdata >= 32'd2) |=> $stable(cur_on_q));

    assert_sync_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sync_start |-> busy_q);

    assert_sync_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && index_q == 32'd21) |=> sync_start);

endmodule

bind display_regport regport_checker #(.MAX_WIDTH(MAX_WIDTH), .MAX_HEIGHT(MAX_HEIGHT)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
    .acc_port(acc_port), .acc_wdata(acc_wdata), .index_q(index_q),
    .ver_q(ver_q), .width_q(width_q), .height_q(height_q),
    .cur_on_q(cur_on_q), .busy_q(busy_q), .sync_start(sync_start),
    .rd_valid(rd_valid)
);

// File: tb/display_regport_bench.sv
// Bench for display_regport: a vector table walked by one loop, then
// directed tests for selector, inert ports, sync handshake and reset.
module display_regport_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_we = 1'b0;
    logic [1:0]  acc_port = 2'd0;
    logic [31:0] acc_wdata = 32'd0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        sync_start;
    logic        consumer_idle = 1'b1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    display_regport u_display_regport (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
        .acc_port(acc_port), .acc_wdata(acc_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .sync_start(sync_start), .consumer_idle(consumer_idle)
    );

    // Entry: {selector[15:0], write_flag, write_value[31:0], expected[31:0]}
    localparam int NV = 34;
    localparam logic [80:0] VEC [NV] = '{
        {16'd0,    1'b0, 32'h0,         32'h9000_0002},
        {16'd0,    1'b1, 32'h9000_0001, 32'h9000_0001},
        {16'd0,    1'b1, 32'h1234_5678, 32'h9000_0001},
        {16'd0,    1'b1, 32'h9000_0000, 32'h9000_0000},
        {16'd2,    1'b0, 32'h0,         32'd640},
        {16'd2,    1'b1, 32'd2368,      32'd2368},
        {16'd2,    1'b1, 32'd2369,      32'd2368},
        {16'd3,    1'b1, 32'd1770,      32'd1770},
        {16'd3,    1'b1, 32'd1771,      32'd1770},
        {16'd4,    1'b0, 32'h0,         32'd2368},
        {16'd5,    1'b0, 32'h0,         32'd1770},
        {16'd6,    1'b0, 32'h0,         32'd24},
        {16'd7,    1'b0, 32'h0,         32'd32},
        {16'd12,   1'b0, 32'h0,         32'd9472},
        {16'd17,   1'b0, 32'h0,         32'h0000_00E3},
        {16'd27,   1'b0, 32'h0,         32'd0},
        {16'd27,   1'b1, 32'd1,         32'd1},
        {16'd27,   1'b1, 32'd2,         32'd1},
        {16'd27,   1'b1, 32'd3,         32'd1},
        {16'd27,   1'b1, 32'd0,         32'd0},
        {16'd27,   1'b1, 32'd3,         32'd0},
        {16'd27,   1'b1, 32'd2,         32'd0},
        {16'd25,   1'b1, 32'h0000_ABCD, 32'h0000_ABCD},
        {16'd1024, 1'b1, 32'd5,         32'd0},
        {16'd1791, 1'b1, 32'd7,         32'd0},
        {16'd100,  1'b1, 32'd9,         32'd0},
        {16'd1792, 1'b1, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        {16'd1807, 1'b1, 32'h0000_0011, 32'h0000_0011},
        {16'd1808, 1'b1, 32'd3,         32'd0},
        {16'd29,   1'b0, 32'h0,         32'd16},
        {16'd1,    1'b1, 32'd5,         32'd1},
        {16'd20,   1'b1, 32'd0,         32'd0},
        {16'd23,   1'b1, 32'h0000_5001, 32'h0000_5001},
        {16'd1792, 1'b0, 32'h0,         32'hDEAD_BEEF}
    };

    function automatic string tag_of(input int sel);
        case (sel)
            0:          return "R2";
            2, 3:       return "R3";
            4, 5:       return "R4";
            6, 7, 12:   return "R5";
            17:         return "R6";
            25, 27:     return "R7";
            1, 20, 23:  return "R13";
            29, 1792, 1807, 1808: return "R9";
            default:    return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] port, input logic [31:0] data);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_port = port; acc_wdata = data;
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] port, output logic [31:0] data, output logic valid);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b0; acc_port = port;
        @(negedge clk);
        acc_en = 1'b0;
        data = rd_data; valid = rd_valid;
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic v;
        apply_reset();

        // R12: outputs idle right after reset.
        @(negedge clk);
        check("R12 rd_valid", {31'd0, rd_valid}, 32'd0);
        check("R12 sync_start", {31'd0, sync_start}, 32'd0);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            int sel;
            sel = int'(VEC[i][80:65]);
            bus_write(2'd0, 32'(VEC[i][80:65]));
            if (VEC[i][64]) bus_write(2'd1, VEC[i][63:32]);
            bus_read(2'd1, d, v);
            check(tag_of(sel), d, VEC[i][31:0]);
        end

        // R1: selector readback and read valid.
        bus_write(2'd0, 32'hA5A5_1234);
        bus_read(2'd0, d, v);
        check("R1 selector", d, 32'hA5A5_1234);
        check("R1 valid", {31'd0, v}, 32'd1);
        @(negedge clk);
        check("R1 valid drops", {31'd0, rd_valid}, 32'd0);

        // R11: inert ports.
        bus_read(2'd2, d, v);
        check("R11 port2", d, 32'd0);
        bus_read(2'd3, d, v);
        check("R11 port3", d, 32'hFFFF_FFFF);
        bus_write(2'd2, 32'h55);
        bus_write(2'd3, 32'h66);
        bus_read(2'd0, d, v);
        check("R11 selector kept", d, 32'hA5A5_1234);

        // R10: sync strobe and busy handshake.
        consumer_idle = 1'b0;
        bus_write(2'd0, 32'd21);
        bus_write(2'd1, 32'd0);
        check("R10 strobe", {31'd0, sync_start}, 32'd1);
        @(negedge clk);
        check("R10 strobe ends", {31'd0, sync_start}, 32'd0);
        bus_write(2'd0, 32'd22);
        bus_read(2'd1, d, v);
        check("R10 busy held", d, 32'd1);
        consumer_idle = 1'b1;
        repeat (2) @(negedge clk);
        bus_read(2'd1, d, v);
        check("R10 busy cleared", d, 32'd0);

        // R12: reset returns defaults.
        bus_write(2'd0, 32'd27);
        bus_write(2'd1, 32'd1);
        apply_reset();
        bus_read(2'd0, d, v);
        check("R12 selector", d, 32'd0);
        bus_write(2'd0, 32'd2);
        bus_read(2'd1, d, v);
        check("R12 width", d, 32'd640);
        bus_write(2'd0, 32'd3);
        bus_read(2'd1, d, v);
        check("R12 height", d, 32'd480);
        bus_write(2'd0, 32'd27);
        bus_read(2'd1, d, v);
        check("R12 cursor", d, 32'd0);
        bus_write(2'd0, 32'd1);
        bus_read(2'd1, d, v);
        check("R12 enable", d, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule